// File: doc/BRIEF.md
# Masked Write Port with Row-Latched Bit Mask

This block is the write front end and storage model of a 16-bit-wide memory. Four active-low strobes arrive asynchronously: a row strobe, a strobe for each byte lane's column, and a write strobe. Each is synchronized to the system clock, and its edges are found there. The row address is taken when the row strobe falls. If the write strobe is already low at that moment, the word on the shared data bus is taken as a bit mask for the whole row cycle. Otherwise the row cycle writes without masking.

Inside a row cycle, a write happens when both a column strobe fall and a write strobe fall have been seen. The data is taken at whichever of the two comes later. Each byte lane is written only if its column strobe is low at that moment. Each bit is written only if its mask bit is 1. The mask is dropped when the row strobe rises, so it never reaches the next row cycle. A probe port reads any stored word combinationally, and a debug port shows the latched mask.

Top module: `bitmask_wr_port`

## Requirements
- R1: After reset, `write_done_o` is 0, `mask_valid_o` is 0 and `mask_dbg_o` is 0.
- R2: If `wr_stb_n` is low when `row_stb_n` falls, the value on `dq_i` is latched as the mask. `mask_valid_o` is then 1 and `mask_dbg_o` shows the mask until `row_stb_n` rises.
- R3: If `wr_stb_n` is high when `row_stb_n` falls, `mask_valid_o` stays 0, and every bit of each enabled byte lane is written.
- R4: In a masked row cycle, a mask bit of 1 lets the matching data bit be written, and a mask bit of 0 keeps the stored bit.
- R5: If `wr_stb_n` falls after the first column strobe fall, the data is taken at the `wr_stb_n` fall. Bus values present at the column strobe fall are not stored.
- R6: If `wr_stb_n` falls before the first column strobe fall, the data is taken at the column strobe fall.
- R7: `col_lo_stb_n` low at the write moment enables bits 7..0, and `col_hi_stb_n` low enables bits 15..8. A lane whose strobe is high is left unchanged.
- R8: If both column strobes are high at the write moment, the word is unchanged and `write_done_o` does not pulse.
- R9: When `row_stb_n` rises, `mask_valid_o` and `mask_dbg_o` return to 0, and the next unmasked row cycle writes all bits.
- R10: The row address is taken at the `row_stb_n` fall. The column address is taken at the first column strobe fall of a write. Later address changes do not move the write.
- R11: `write_done_o` is high for exactly one clock for each word written.
- R12: After a write, a new column strobe fall and a new `wr_stb_n` fall in the same row cycle write a second word, using the same mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| row_stb_n | input | 1 | Active-low row strobe, asynchronous |
| col_lo_stb_n | input | 1 | Active-low column strobe for the lower byte lane |
| col_hi_stb_n | input | 1 | Active-low column strobe for the upper byte lane |
| wr_stb_n | input | 1 | Active-low write strobe; also selects masking at the row fall |
| addr_i | input | 6 | Multiplexed row/column address |
| dq_i | input | 16 | Shared mask/data bus |
| probe_row_i | input | 6 | Row of the word shown on the probe |
| probe_col_i | input | 4 | Column of the word shown on the probe |
| probe_data_o | output | 16 | Stored word at the probe address |
| write_done_o | output | 1 | One-clock pulse per committed write |
| mask_valid_o | output | 1 | A row-latched mask is in force |
| mask_dbg_o | output | 16 | Currently latched mask, 0 when none |

## Verification
The bench checks both orders of the column and write strobe falls. It changes the bus between the two falls, so a design that took data at the wrong edge stores the stale word. It writes masked words over known contents: a design with the mask polarity inverted, or one that ignored the mask, would change the protected bits. A column strobe that rises before the write strobe falls must leave the word untouched and give no done pulse. The bench also moves the address after the first column strobe fall, and runs an unmasked row cycle right after a masked one to catch a mask that carried over.

// File: rtl/bmw_pkg.sv
package bmw_pkg;
  typedef enum logic [1:0] {
    STB_ROW = 2'd0,
    STB_LO  = 2'd1,
    STB_HI  = 2'd2,
    STB_WR  = 2'd3
  } strobe_e;
  localparam int NUM_STB = 4;
endpackage

// File: rtl/bmw_strobe_sync.sv
module bmw_strobe_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] stb_n_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] prv_o
);
  for (genvar i = 0; i < N; i++) begin : g_sync
    logic s1_q, s2_q, p_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
        p_q  <= 1'b1;
      end else begin
        s1_q <= stb_n_i[i];
        s2_q <= s1_q;
        p_q  <= s2_q;
      end
    end
    assign lvl_o[i] = s2_q;
    assign prv_o[i] = p_q;
  end
endmodule

// File: rtl/bmw_store.sv
module bmw_store #(
  parameter int DW    = 16,
  parameter int ROW_W = 6,
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             wr_en_i,
  input  logic [ROW_W-1:0] wr_row_i,
  input  logic [COL_W-1:0] wr_col_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [DW-1:0]    wr_bits_i,
  input  logic [ROW_W-1:0] rd_row_i,
  input  logic [COL_W-1:0] rd_col_i,
  output logic [DW-1:0]    rd_data_o
);
  localparam int IDX_W = ROW_W + COL_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0]    mem [DEPTH];
  logic [IDX_W-1:0] wr_idx;
  logic [DW-1:0]    merged;

  assign wr_idx = {wr_row_i, wr_col_i};

  always_comb begin
    merged = (mem[wr_idx] & ~wr_bits_i) | (wr_data_i & wr_bits_i);
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_idx] <= merged;
  end

  assign rd_data_o = mem[{rd_row_i, rd_col_i}];
endmodule

// File: rtl/bmw_ctrl.sv
module bmw_ctrl
  import bmw_pkg::*;
#(
  parameter int DW    = 16,
  parameter int ROW_W = 6,
  parameter int COL_W = 4,
  parameter int AW    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_STB-1:0] lvl_i,
  input  logic [NUM_STB-1:0] prv_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      dq_i,
  output logic               wr_en_o,
  output logic [ROW_W-1:0]   wr_row_o,
  output logic [COL_W-1:0]   wr_col_o,
  output logic [DW-1:0]      wr_data_o,
  output logic [DW-1:0]      wr_bits_o,
  output logic               done_o,
  output logic               mask_valid_o,
  output logic [DW-1:0]      mask_o
);
  localparam int LO_W = DW / 2;
  localparam int HI_W = DW - LO_W;

  logic [NUM_STB-1:0] fall;
  logic row_rise, cas_fall, commit;
  logic lo_on, hi_on, cas_now, wr_now, first_cas;
  logic [DW-1:0] mask_eff, lane_bits;

  logic             row_act_q, row_act_d;
  logic             mvalid_q, mvalid_d;
  logic [DW-1:0]    mask_q, mask_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             cas_seen_q, cas_seen_d;
  logic             wr_seen_q, wr_seen_d;
  logic             done_q, done_d;

  assign fall     = prv_i & ~lvl_i;
  assign row_rise = ~prv_i[STB_ROW] & lvl_i[STB_ROW];
  assign cas_fall = fall[STB_LO] | fall[STB_HI];
  assign lo_on    = ~lvl_i[STB_LO];
  assign hi_on    = ~lvl_i[STB_HI];

  always_comb begin
    row_act_d  = row_act_q;
    mvalid_d   = mvalid_q;
    mask_d     = mask_q;
    row_d      = row_q;
    col_d      = col_q;
    cas_seen_d = cas_seen_q;
    wr_seen_d  = wr_seen_q;
    first_cas  = row_act_q & cas_fall & ~cas_seen_q;
    cas_now    = cas_seen_q | cas_fall;
    wr_now     = wr_seen_q | fall[STB_WR];
    commit     = row_act_q & cas_now & wr_now;
    wr_col_o   = first_cas ? addr_i[COL_W-1:0] : col_q;
    mask_eff   = mvalid_q ? mask_q : {DW{1'b1}};
    lane_bits  = {{HI_W{hi_on}}, {LO_W{lo_on}}};

    if (fall[STB_ROW]) begin
      row_act_d  = 1'b1;
      row_d      = addr_i[ROW_W-1:0];
      mvalid_d   = ~lvl_i[STB_WR];
      mask_d     = lvl_i[STB_WR] ? '0 : dq_i;
      cas_seen_d = 1'b0;
      wr_seen_d  = 1'b0;
    end else if (row_rise) begin
      row_act_d  = 1'b0;
      mvalid_d   = 1'b0;
      mask_d     = '0;
      cas_seen_d = 1'b0;
      wr_seen_d  = 1'b0;
    end else if (commit) begin
      cas_seen_d = 1'b0;
      wr_seen_d  = 1'b0;
    end else if (row_act_q) begin
      if (first_cas) begin
        cas_seen_d = 1'b1;
        col_d      = addr_i[COL_W-1:0];
      end
      if (fall[STB_WR]) wr_seen_d = 1'b1;
    end

    wr_en_o   = commit & (lo_on | hi_on);
    wr_row_o  = row_q;
    wr_data_o = dq_i;
    wr_bits_o = mask_eff & lane_bits;
    done_d    = wr_en_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_act_q  <= 1'b0;
      mvalid_q   <= 1'b0;
      mask_q     <= '0;
      row_q      <= '0;
      col_q      <= '0;
      cas_seen_q <= 1'b0;
      wr_seen_q  <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      row_act_q  <= row_act_d;
      mvalid_q   <= mvalid_d;
      mask_q     <= mask_d;
      row_q      <= row_d;
      col_q      <= col_d;
      cas_seen_q <= cas_seen_d;
      wr_seen_q  <= wr_seen_d;
      done_q     <= done_d;
    end
  end

  assign done_o       = done_q;
  assign mask_valid_o = mvalid_q;
  assign mask_o       = mask_q;

  AST_MASK_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    mvalid_q |-> row_act_q); // R2
  AST_UNMASKED_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (fall[STB_ROW] && lvl_i[STB_WR]) |=> !mvalid_q); // R3
  AST_MASK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    row_rise |=> (!mvalid_q && mask_q == '0)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R11
  AST_DONE_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(!(lvl_i[STB_LO] && lvl_i[STB_HI]))); // R8
endmodule

// File: rtl/bitmask_wr_port.sv
module bitmask_wr_port
  import bmw_pkg::*;
#(
  parameter int DW    = 16,
  parameter int ROW_W = 6,
  parameter int COL_W = 4,
  localparam int AW   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_stb_n,
  input  logic             col_lo_stb_n,
  input  logic             col_hi_stb_n,
  input  logic             wr_stb_n,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    dq_i,
  input  logic [ROW_W-1:0] probe_row_i,
  input  logic [COL_W-1:0] probe_col_i,
  output logic [DW-1:0]    probe_data_o,
  output logic             write_done_o,
  output logic             mask_valid_o,
  output logic [DW-1:0]    mask_dbg_o
);
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic [NUM_STB-1:0] stb_n, lvl, prv;
  always_comb begin
    stb_n          = '1;
    stb_n[STB_ROW] = row_stb_n;
    stb_n[STB_LO]  = col_lo_stb_n;
    stb_n[STB_HI]  = col_hi_stb_n;
    stb_n[STB_WR]  = wr_stb_n;
  end

  bmw_strobe_sync #(.N(NUM_STB)) u_sync (
    .clk(clk), .rst_n(rst_s2_q), .stb_n_i(stb_n), .lvl_o(lvl), .prv_o(prv)
  );

  // Address and bus delayed by two stages to line up with synchronized strobes
  logic [AW-1:0] addr_d1_q, addr_d2_q;
  logic [DW-1:0] dq_d1_q, dq_d2_q;
  always_ff @(posedge clk or negedge rst_s2_q) begin
    if (!rst_s2_q) begin
      addr_d1_q <= '0;
      addr_d2_q <= '0;
      dq_d1_q   <= '0;
      dq_d2_q   <= '0;
    end else begin
      addr_d1_q <= addr_i;
      addr_d2_q <= addr_d1_q;
      dq_d1_q   <= dq_i;
      dq_d2_q   <= dq_d1_q;
    end
  end

  logic             wr_en;
  logic [ROW_W-1:0] wr_row;
  logic [COL_W-1:0] wr_col;
  logic [DW-1:0]    wr_data, wr_bits;

  bmw_ctrl #(.DW(DW), .ROW_W(ROW_W), .COL_W(COL_W), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_s2_q), .lvl_i(lvl), .prv_i(prv),
    .addr_i(addr_d2_q), .dq_i(dq_d2_q),
    .wr_en_o(wr_en), .wr_row_o(wr_row), .wr_col_o(wr_col),
    .wr_data_o(wr_data), .wr_bits_o(wr_bits),
    .done_o(write_done_o), .mask_valid_o(mask_valid_o), .mask_o(mask_dbg_o)
  );

  bmw_store #(.DW(DW), .ROW_W(ROW_W), .COL_W(COL_W)) u_store (
    .clk(clk), .wr_en_i(wr_en), .wr_row_i(wr_row), .wr_col_i(wr_col),
    .wr_data_i(wr_data), .wr_bits_i(wr_bits),
    .rd_row_i(probe_row_i), .rd_col_i(probe_col_i), .rd_data_o(probe_data_o)
  );
endmodule

// File: tb/tb_bitmask_wr_port.sv
module tb_bitmask_wr_port;
  logic clk = 1'b0;
  logic rst_n;
  logic row_n, lo_n, hi_n, we_n;
  logic [5:0]  addr, prow;
  logic [3:0]  pcol;
  logic [15:0] dq;
  logic [15:0] pdata, mdbg;
  logic        done, mvalid;
  int checks = 0, fails = 0, done_cnt = 0;
  logic long_pulse = 1'b0, done_prev = 1'b0;

  always #10 clk = ~clk;

  bitmask_wr_port dut (
    .clk(clk), .rst_n(rst_n), .row_stb_n(row_n), .col_lo_stb_n(lo_n),
    .col_hi_stb_n(hi_n), .wr_stb_n(we_n), .addr_i(addr), .dq_i(dq),
    .probe_row_i(prow), .probe_col_i(pcol), .probe_data_o(pdata),
    .write_done_o(done), .mask_valid_o(mvalid), .mask_dbg_o(mdbg)
  );

  always @(posedge clk) begin
    if (done) done_cnt <= done_cnt + 1;
    if (done && done_prev) long_pulse <= 1'b1;
    done_prev <= done;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic peek(input string req, input logic [5:0] r, input logic [3:0] c,
                      input logic [15:0] exp);
    prow = r; pcol = c; #1;
    chk(req, {16'h0, pdata}, {16'h0, exp});
  endtask

  task automatic row_down(input logic [5:0] r, input logic masked, input logic [15:0] m);
    addr = r; dq = m; we_n = ~masked; tick(4);
    row_n = 1'b0; tick(4);
    we_n = 1'b1; tick(4);
  endtask

  task automatic row_up();
    lo_n = 1'b1; hi_n = 1'b1; we_n = 1'b1; tick(4);
    row_n = 1'b1; tick(4);
  endtask

  task automatic plain_write(input logic [5:0] r, input logic [3:0] c, input logic [15:0] d);
    row_down(r, 1'b0, 16'h0);
    addr = {2'b0, c}; dq = d; tick(2);
    lo_n = 1'b0; hi_n = 1'b0; tick(4);
    we_n = 1'b0; tick(4);
    row_up();
  endtask

  task automatic t_reset();
    chk("R1 done", {31'h0, done}, 32'h0);
    chk("R1 valid", {31'h0, mvalid}, 32'h0);
    chk("R1 mask", {16'h0, mdbg}, 32'h0);
  endtask

  task automatic t_unmasked();
    int c0 = done_cnt;
    plain_write(6'd5, 4'd3, 16'hA5C3);
    peek("R3 full word", 6'd5, 4'd3, 16'hA5C3);
    chk("R11 one pulse", done_cnt - c0, 1);
    row_down(6'd5, 1'b0, 16'h1234);
    chk("R3 no mask valid", {31'h0, mvalid}, 32'h0);
    row_up();
  endtask

  task automatic t_masked();
    plain_write(6'd10, 4'd2, 16'hFFFF);
    row_down(6'd10, 1'b1, 16'h0F0F);
    chk("R2 valid", {31'h0, mvalid}, 32'h1);
    chk("R2 mask", {16'h0, mdbg}, 32'h0F0F);
    addr = 6'd2; dq = 16'h0000; tick(2);
    lo_n = 1'b0; hi_n = 1'b0; tick(4);
    we_n = 1'b0; tick(4);
    peek("R4 masked bits", 6'd10, 4'd2, 16'hF0F0);
    row_up();
    chk("R9 valid cleared", {31'h0, mvalid}, 32'h0);
    chk("R9 mask cleared", {16'h0, mdbg}, 32'h0);
    plain_write(6'd10, 4'd2, 16'h1234);
    peek("R9 no carryover", 6'd10, 4'd2, 16'h1234);
  endtask

  task automatic t_late();
    row_down(6'd20, 1'b0, 16'h0);
    addr = 6'd7; dq = 16'h1111; tick(2);
    lo_n = 1'b0; hi_n = 1'b0; tick(4);
    dq = 16'hBEEF; tick(4);
    we_n = 1'b0; tick(4);
    dq = 16'h9999; tick(4);
    row_up();
    peek("R5 late write data", 6'd20, 4'd7, 16'hBEEF);
  endtask

  task automatic t_early();
    row_down(6'd21, 1'b0, 16'h0);
    addr = 6'd8; dq = 16'h2222; tick(2);
    we_n = 1'b0; tick(4);
    dq = 16'h7777; tick(4);
    lo_n = 1'b0; hi_n = 1'b0; tick(4);
    dq = 16'h3333; tick(4);
    row_up();
    peek("R6 early write data", 6'd21, 4'd8, 16'h7777);
  endtask

  task automatic t_lanes();
    plain_write(6'd1, 4'd1, 16'h0000);
    plain_write(6'd1, 4'd2, 16'h0000);
    row_down(6'd1, 1'b0, 16'h0);
    addr = 6'd1; dq = 16'hFFFF; tick(2);
    lo_n = 1'b0; tick(4); we_n = 1'b0; tick(4);
    row_up();
    peek("R7 lower lane", 6'd1, 4'd1, 16'h00FF);
    row_down(6'd1, 1'b0, 16'h0);
    addr = 6'd2; dq = 16'hFFFF; tick(2);
    hi_n = 1'b0; tick(4); we_n = 1'b0; tick(4);
    row_up();
    peek("R7 upper lane", 6'd1, 4'd2, 16'hFF00);
  endtask

  task automatic t_no_lane();
    int c0;
    plain_write(6'd2, 4'd0, 16'hABCD);
    c0 = done_cnt;
    row_down(6'd2, 1'b0, 16'h0);
    addr = 6'd0; dq = 16'h0000; tick(2);
    lo_n = 1'b0; hi_n = 1'b0; tick(4);
    lo_n = 1'b1; hi_n = 1'b1; tick(4);
    we_n = 1'b0; tick(4);
    row_up();
    peek("R8 word kept", 6'd2, 4'd0, 16'hABCD);
    chk("R8 no done", done_cnt - c0, 0);
  endtask

  task automatic t_addr();
    plain_write(6'd7, 4'd9, 16'h0000);
    row_down(6'd7, 1'b0, 16'h0);
    addr = 6'd4; dq = 16'h5A5A; tick(2);
    lo_n = 1'b0; tick(4);
    addr = 6'd9; tick(4);
    hi_n = 1'b0; tick(4);
    addr = 6'd3; we_n = 1'b0; tick(4);
    row_up();
    peek("R10 column kept", 6'd7, 4'd4, 16'h5A5A);
    peek("R10 later column untouched", 6'd7, 4'd9, 16'h0000);
  endtask

  task automatic t_page();
    int c0;
    plain_write(6'd3, 4'd5, 16'hFFFF);
    plain_write(6'd3, 4'd6, 16'hFFFF);
    c0 = done_cnt;
    row_down(6'd3, 1'b1, 16'hFF00);
    addr = 6'd5; dq = 16'h0000; tick(2);
    lo_n = 1'b0; hi_n = 1'b0; tick(4); we_n = 1'b0; tick(4);
    lo_n = 1'b1; hi_n = 1'b1; we_n = 1'b1; tick(4);
    addr = 6'd6; tick(2);
    lo_n = 1'b0; hi_n = 1'b0; tick(4); we_n = 1'b0; tick(4);
    row_up();
    peek("R12 first word", 6'd3, 4'd5, 16'h00FF);
    peek("R12 second word", 6'd3, 4'd6, 16'h00FF);
    chk("R12 two commits", done_cnt - c0, 2);
  endtask

  initial begin
    rst_n = 1'b0; row_n = 1'b1; lo_n = 1'b1; hi_n = 1'b1; we_n = 1'b1;
    addr = '0; dq = '0; prow = '0; pcol = '0;
    tick(3);
    rst_n = 1'b1;
    tick(6);
    t_reset();
    t_unmasked();
    t_masked();
    t_late();
    t_early();
    t_lanes();
    t_no_lane();
    t_addr();
    t_page();
    chk("R11 pulse width", {31'h0, long_pulse}, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule